// File: doc/BRIEF.md
# Shared-Line Stereo Slot Transmitter

This block is the serial output stage of one of two sample sources that share a single data wire in an I2S-style stereo link. Each instance takes a 24-bit two's-complement sample together with five status flags. It builds a 32-bit slot word from them and shifts the word out, MSB first, during its own half of a 64-bit-clock stereo frame. A one-bit strap decides whether the instance owns the left half (word select low) or the right half (word select high).

The block is always the clock master. It divides its system clock into a serial bit clock and derives word select from that bit clock. It also pulls a ready strobe low during the last bit of each frame. Both instances leave reset in the same state, so either one's bit clock and word select can serve the link.

The data pin comes with an output-enable. The enable rises and falls on the exact bit-clock falling edge where word select changes. The pad three-states outside the owning half. One instance therefore hands the wire to the other on that shared edge, and the two never drive it at the same time.

A sample that arrives while the instance is transmitting waits in a holding register. It is loaded at the start of the next slot that instance owns.

Top module: `stereo_slot_tx`

## Requirements
- R1: While reset is held and in the first cycle after it, `sck_o` is 0, `ws_o` is 1, `rdy_n_o` is 1 and `sd_oe_o` is 0.
- R2: `sck_o` holds each level for exactly `SCK_HALF` system clock cycles.
- R3: `ws_o` changes only on a falling edge of `sck_o`. Each level lasts exactly 32 bit clocks, so a frame is 64 bit clocks, and the low half comes first.
- R4: An instance with `chan_sel` = 0 drives only while `ws_o` is low, and one with `chan_sel` = 1 drives only while `ws_o` is high.
- R5: The slot word is sent MSB first. Bits 31..8 hold the sample. Bits 7..3 hold `flags_in[4:0]`, where [4] means data valid, [3] over-range, [2] unfiltered, [1] low-power and [0] filter settled. Bit 2 holds `chan_sel`, and bits 1..0 are 0.
- R6: `sd_o` changes only on falling edges of `sck_o`, so a receiver samples it on rising edges.
- R7: `sd_oe_o` changes only on the `sck_o` falling edge where `ws_o` changes, which ends the 32nd bit of the slot. Two instances with opposite straps never have their enables high at the same time.
- R8: `rdy_n_o` goes low for exactly one bit-clock period, only while `ws_o` is high, and returns high on the same edge where `ws_o` falls.
- R9: The pair (`sample_in`, `flags_in`) captured by `sample_stb` is loaded at the start of the instance's next own slot. A strobe during the slot leaves the current word unchanged. When no strobe arrives, the last captured pair is repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_sel | input | 1 | Channel strap: 0 left (drives while word select low), 1 right |
| sample_in | input | SAMPLE_W | Two's-complement sample |
| flags_in | input | 5 | Status flags: valid, over-range, unfiltered, low-power, filter settled |
| sample_stb | input | 1 | One-cycle strobe capturing `sample_in` and `flags_in` |
| sck_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select, low for the left half of the frame |
| rdy_n_o | output | 1 | Active-low ready strobe ahead of each new frame |
| sd_o | output | 1 | Serial data bit for the pad |
| sd_oe_o | output | 1 | Pad output-enable; the pad is high impedance while 0 |

## Verification
The assertions take `chan_sel` as a strap that does not change after reset. They also take `sample_stb` as a short pulse in system-clock time, which never lands in the cycle of the instance's own slot load. The bench ties the two straps to opposite constants. It pulses each strobe for one cycle, either right after the ready strobe falls (one bit clock before the left load) or well inside a running slot, so no strobe ever coincides with a load. Both instances come out of one shared reset, so their clocks stay in phase as the shared-wire arrangement requires.

// File: rtl/stx_pkg.sv
// Package: shared types for the stereo slot transmitter.
// Assumes: the five status flags are always carried in the order of the struct below.
package stx_pkg;

    // Number of status flags carried in each slot.
    localparam int FLAG_W = 5;

    // Half of the stereo frame an instance owns.
    typedef enum logic {
        PHASE_LEFT  = 1'b0,
        PHASE_RIGHT = 1'b1
    } stx_phase_e;

    // Status flags, most significant first as they appear on the wire.
    typedef struct packed {
        logic valid;
        logic over_range;
        logic unfiltered;
        logic low_power;
        logic filt_settled;
    } stx_flags_t;

endpackage

// File: rtl/stx_clkgen.sv
// Module: bit clock, word select and ready strobe generator.
// Makes sck by dividing clk, counts bits of a 2*SLOT_W frame on sck falling
// edges, and derives word select and the ready strobe from that count.
// Assumes: 2*SLOT_W is a power of two, so the bit counter wraps naturally.
module stx_clkgen #(
    parameter int SCK_HALF = 2,
    parameter int SLOT_W   = 32,
    localparam int CNT_W   = $clog2(2 * SLOT_W),
    localparam int DIV_W   = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             sck,
    output logic             ws,
    output logic             rdy_n,
    output logic             fall_tick,
    output logic [CNT_W-1:0] nxt_bit
);

    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] bit_q;
    logic             wrap;

    // Divider end-of-half detection and the bit index that follows this fall.
    always_comb begin
        wrap      = (div_q == DIV_W'(SCK_HALF - 1));
        fall_tick = wrap & sck;
        nxt_bit   = bit_q + CNT_W'(1);
    end

    // Divider, clock level, bit counter, word select and ready strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            sck   <= 1'b0;
            bit_q <= '1;
            ws    <= 1'b1;
            rdy_n <= 1'b1;
        end else begin
            div_q <= wrap ? '0 : div_q + DIV_W'(1);
            if (wrap) begin
                sck <= ~sck;
            end
            if (fall_tick) begin
                bit_q <= nxt_bit;
                ws    <= nxt_bit[CNT_W-1];
                rdy_n <= ~(&nxt_bit);
            end
        end
    end

endmodule

// File: rtl/stx_sample_hold.sv
// Module: holding register for the next sample and its flags.
// Captures on the strobe; the slot shifter reads it only at slot start.
// Assumes: the strobe is one cycle wide and values are valid with it.
module stx_sample_hold
    import stx_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stb,
    input  logic [SAMPLE_W-1:0] sample_d,
    input  stx_flags_t          flags_d,
    output logic [SAMPLE_W-1:0] sample_q,
    output stx_flags_t          flags_q
);

    // Keep the most recently strobed sample and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_q <= '0;
            flags_q  <= '0;
        end else if (stb) begin
            sample_q <= sample_d;
            flags_q  <= flags_d;
        end
    end

endmodule

// File: rtl/stx_slot_shifter.sv
// Module: slot shift register and output-enable for one channel.
// Loads the word on the fall that opens the owned half, shifts on each later
// fall, and drops the enable on the fall that opens the other half.
// Assumes: fall_tick and nxt_bit come from stx_clkgen.
module stx_slot_shifter
    import stx_pkg::*;
#(
    parameter int SLOT_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stx_phase_e        own_phase,
    input  logic              fall_tick,
    input  logic [CNT_W-1:0]  nxt_bit,
    input  logic [SLOT_W-1:0] load_word,
    output logic              sd,
    output logic              sd_oe
);

    logic [SLOT_W-1:0] shreg;
    logic              in_own;
    logic              slot_start;

    // Ownership of the bit that begins at this fall, and slot opening.
    always_comb begin
        in_own     = (nxt_bit[CNT_W-1] == own_phase);
        slot_start = in_own && (nxt_bit[CNT_W-2:0] == '0);
    end

    // Load, shift and enable updates on sck falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            sd_oe <= 1'b0;
        end else if (fall_tick) begin
            sd_oe <= in_own;
            if (slot_start) begin
                shreg <= load_word;
            end else if (in_own) begin
                shreg <= {shreg[SLOT_W-2:0], 1'b0};
            end
        end
    end

    // MSB of the shift register is the current bit.
    always_comb sd = shreg[SLOT_W-1];

endmodule

// File: rtl/stereo_slot_tx.sv
// Module: top of the shared-line stereo slot transmitter.
// Ties together clock generation, sample holding and the slot shifter, and
// assembles the slot word {sample, flags, channel bit, zero padding}.
// Assumes: chan_sel is a static strap; SLOT_W - SAMPLE_W >= FLAG_W + 2.
module stereo_slot_tx
    import stx_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int SLOT_W   = 32,
    parameter int SCK_HALF = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                chan_sel,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic [FLAG_W-1:0]   flags_in,
    input  logic                sample_stb,
    output logic                sck_o,
    output logic                ws_o,
    output logic                rdy_n_o,
    output logic                sd_o,
    output logic                sd_oe_o
);

    localparam int CNT_W    = $clog2(2 * SLOT_W);
    localparam int STATUS_W = SLOT_W - SAMPLE_W;
    localparam int PAD_W    = STATUS_W - FLAG_W - 1;

    logic                fall_tick;
    logic [CNT_W-1:0]    nxt_bit;
    logic [SAMPLE_W-1:0] held_sample;
    stx_flags_t          held_flags;
    stx_flags_t          flags_typed;
    logic [SLOT_W-1:0]   load_word;
    stx_phase_e          own_phase;

    // Map raw inputs onto the package types.
    always_comb begin
        flags_typed = stx_flags_t'(flags_in);
        own_phase   = stx_phase_e'(chan_sel);
    end

    stx_clkgen #(
        .SCK_HALF (SCK_HALF),
        .SLOT_W   (SLOT_W)
    ) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck       (sck_o),
        .ws        (ws_o),
        .rdy_n     (rdy_n_o),
        .fall_tick (fall_tick),
        .nxt_bit   (nxt_bit)
    );

    stx_sample_hold #(
        .SAMPLE_W (SAMPLE_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (sample_stb),
        .sample_d (sample_in),
        .flags_d  (flags_typed),
        .sample_q (held_sample),
        .flags_q  (held_flags)
    );

    // Slot word: sample, then flags, channel bit and zero padding.
    always_comb load_word = {held_sample, held_flags, chan_sel, {PAD_W{1'b0}}};

    stx_slot_shifter #(
        .SLOT_W (SLOT_W),
        .CNT_W  (CNT_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .own_phase (own_phase),
        .fall_tick (fall_tick),
        .nxt_bit   (nxt_bit),
        .load_word (load_word),
        .sd        (sd_o),
        .sd_oe     (sd_oe_o)
    );

endmodule

// File: rtl/stx_checker.sv
// Module: temporal checks on the transmitter's pins, bound to the top.
// Assumes: chan_sel is static after reset.
module stx_checker (
    input logic clk,
    input logic rst_n,
    input logic own_phase,
    input logic sck,
    input logic ws,
    input logic rdy_n,
    input logic sd,
    input logic sd_oe
);

    assert_oe_own_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sd_oe |-> (ws == own_phase));

    assert_ws_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ws) |-> $fell(sck));

    assert_data_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_oe && $past(sd_oe) && !$stable(sd)) |-> $fell(sck));

    assert_oe_at_ws_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sd_oe) |-> !$stable(ws));

    assert_rdy_in_right_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_n |-> ws);

    assert_rdy_ends_at_ws_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_n) |-> $fell(ws));

endmodule

bind stereo_slot_tx stx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .own_phase (chan_sel),
    .sck       (sck_o),
    .ws        (ws_o),
    .rdy_n     (rdy_n_o),
    .sd        (sd_o),
    .sd_oe     (sd_oe_o)
);

// File: tb/sim_stereo_slot_tx.sv
module sim_stereo_slot_tx;

    localparam int CLK_PERIOD = 10;
    localparam int SCK_HALF   = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] sa, sb;
    logic [4:0]  fa, fb;
    logic        stb_a, stb_b;
    logic        sck, ws, rdy_n, sd_a, oe_a;
    logic        sck_b, ws_b, rdy_n_b, sd_b, oe_b;
    tri          sd_bus;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stereo_slot_tx u0 (
        .clk(clk), .rst_n(rst_n), .chan_sel(1'b0), .sample_in(sa), .flags_in(fa),
        .sample_stb(stb_a), .sck_o(sck), .ws_o(ws), .rdy_n_o(rdy_n),
        .sd_o(sd_a), .sd_oe_o(oe_a)
    );

    stereo_slot_tx u1 (
        .clk(clk), .rst_n(rst_n), .chan_sel(1'b1), .sample_in(sb), .flags_in(fb),
        .sample_stb(stb_b), .sck_o(sck_b), .ws_o(ws_b), .rdy_n_o(rdy_n_b),
        .sd_o(sd_b), .sd_oe_o(oe_b)
    );

    // Shared data wire with one three-state driver per instance.
    assign sd_bus = oe_a ? sd_a : 1'bz;
    assign sd_bus = oe_b ? sd_b : 1'bz;

    // Monitor state.
    int          contention = 0, edge_err = 0, sck_err = 0, ws_err = 0;
    int          ws_phases = 0, rdy_err = 0, rdy_pulses = 0, data_err = 0;
    int          sck_run = 0, nbits = 0, rdy_low = 0;
    bit          started = 0, sck_seen = 0, have_phase = 0;
    logic        prev_sck = 0, prev_ws = 1, prev_rdy = 1, prev_sd = 0, cap_ws = 1;
    logic [31:0] cap_word = '0, left_word = '0, right_word = '0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [23:0] s, input logic [4:0] f,
                                             input logic ch);
        return {s, f, ch, 2'b00};
    endfunction

    // Pin monitor sampled on falling clk edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (oe_a && oe_b) contention++;
            if (ws == 1'b0) started = 1;
            if (started && ((oe_a != !ws) || (oe_b != ws))) edge_err++;
            if (sck != prev_sck) begin
                if (sck_seen && sck_run != SCK_HALF) sck_err++;
                sck_seen = 1;
                sck_run  = 1;
            end else begin
                sck_run++;
            end
            if (sck && prev_sck && (sd_bus !== prev_sd)) data_err++;
            if (sck && !prev_sck) begin
                if (ws != cap_ws) begin
                    if (have_phase) begin
                        ws_phases++;
                        if (nbits != 32) ws_err++;
                    end
                    have_phase = 1;
                    cap_ws = ws;
                    nbits  = 0;
                end
                cap_word = {cap_word[30:0], sd_bus};
                nbits++;
                if (nbits == 32) begin
                    if (ws) right_word = cap_word;
                    else    left_word  = cap_word;
                end
            end
            if (!rdy_n) rdy_low++;
            if (rdy_n && !prev_rdy) begin
                rdy_pulses++;
                if (rdy_low != 2 * SCK_HALF || ws != 1'b0 || prev_ws != 1'b1) rdy_err++;
                rdy_low = 0;
            end
            prev_sck = sck;
            prev_ws  = ws;
            prev_rdy = rdy_n;
            prev_sd  = sd_bus;
        end
    end

    task automatic wait_rdy_fall();
        while (rdy_n !== 1'b1) @(negedge clk);
        while (rdy_n !== 1'b0) @(negedge clk);
    endtask

    // Load new values one bit ahead of the left slot, then observe one frame.
    task automatic run_frame(input logic [23:0] a, input logic [4:0] af,
                             input logic [23:0] b, input logic [4:0] bf, input bit load);
        wait_rdy_fall();
        if (load) begin
            sa = a; fa = af; sb = b; fb = bf;
            stb_a = 1; stb_b = 1;
            @(negedge clk);
            stb_a = 0; stb_b = 0;
        end
        wait_rdy_fall();
        repeat (6 * SCK_HALF) @(negedge clk);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            report();
        end
    end

    initial begin
        logic [23:0] s1, s2;
        rst_n = 0; sa = '0; sb = '0; fa = '0; fb = '0; stb_a = 0; stb_b = 0;
        repeat (4) @(negedge clk);
        // R1: reset values while reset is held
        check(sck == 0 && ws == 1 && rdy_n == 1 && !oe_a && !oe_b, "R1 in reset",
              {27'd0, sck, ws, rdy_n, oe_a, oe_b}, 32'b01100);
        rst_n = 1;
        @(negedge clk);
        check(sck == 0 && ws == 1 && rdy_n == 1 && !oe_a && !oe_b, "R1 after release",
              {27'd0, sck, ws, rdy_n, oe_a, oe_b}, 32'b01100);

        // R5/R4: corner samples and a flag sweep
        run_frame(24'h800000, 5'h1F, 24'h7FFFFF, 5'h00, 1);
        check(left_word == exp_word(24'h800000, 5'h1F, 0), "R5 R4 left min", left_word,
              exp_word(24'h800000, 5'h1F, 0));
        check(right_word == exp_word(24'h7FFFFF, 5'h00, 1), "R5 R4 right max", right_word,
              exp_word(24'h7FFFFF, 5'h00, 1));
        for (int i = 0; i < 32; i++) begin
            logic [23:0] va, vb;
            va = 24'(i * 32'h05A3C7 + 32'h123);
            vb = ~va ^ 24'(i << 7);
            run_frame(va, 5'(i), vb, 5'(~i), 1);
            check(left_word == exp_word(va, 5'(i), 0), "R5 left sweep", left_word,
                  exp_word(va, 5'(i), 0));
            check(right_word == exp_word(vb, 5'(~i), 1), "R5 right sweep", right_word,
                  exp_word(vb, 5'(~i), 1));
        end

        // R9: no strobe repeats the held words
        run_frame(24'h0, 5'h0, 24'h0, 5'h0, 1);
        run_frame(24'hFFFFFF, 5'h15, 24'h0, 5'h0A, 0);
        check(left_word == exp_word(24'h0, 5'h0, 0) && right_word == exp_word(24'h0, 5'h0, 1),
              "R9 repeat", left_word, exp_word(24'h0, 5'h0, 0));

        // R9: strobe inside the left slot is deferred
        s1 = 24'hABCDEF; s2 = 24'h135790;
        run_frame(s1, 5'h11, s1, 5'h11, 1);
        repeat (16 * 2 * SCK_HALF) @(negedge clk);
        sa = s2; fa = 5'h0E; stb_a = 1; @(negedge clk); stb_a = 0;
        wait_rdy_fall(); repeat (6 * SCK_HALF) @(negedge clk);
        check(left_word == exp_word(s1, 5'h11, 0), "R9 left mid-slot held", left_word,
              exp_word(s1, 5'h11, 0));
        wait_rdy_fall(); repeat (6 * SCK_HALF) @(negedge clk);
        check(left_word == exp_word(s2, 5'h0E, 0), "R9 left next slot", left_word,
              exp_word(s2, 5'h0E, 0));

        // R9: strobe inside the right slot is deferred
        repeat (48 * 2 * SCK_HALF) @(negedge clk);
        sb = s2; fb = 5'h07; stb_b = 1; @(negedge clk); stb_b = 0;
        wait_rdy_fall(); repeat (6 * SCK_HALF) @(negedge clk);
        check(right_word == exp_word(s1, 5'h11, 1), "R9 right mid-slot held", right_word,
              exp_word(s1, 5'h11, 1));
        wait_rdy_fall(); repeat (6 * SCK_HALF) @(negedge clk);
        check(right_word == exp_word(s2, 5'h07, 1), "R9 right next slot", right_word,
              exp_word(s2, 5'h07, 1));

        // Pin-level summaries gathered by the monitor
        check(sck_err == 0, "R2 sck half period", sck_err, 0);
        check(ws_err == 0 && ws_phases > 60, "R3 ws every 32 bits", ws_err, 0);
        check(contention == 0, "R7 no double drive", contention, 0);
        check(edge_err == 0, "R7 R4 enable follows ws edge", edge_err, 0);
        check(data_err == 0, "R6 data stable while sck high", data_err, 0);
        check(rdy_err == 0 && rdy_pulses > 30, "R8 ready pulse", rdy_err, 0);
        done = 1;
        report();
    end

endmodule